// File: doc/BRIEF.md
# Serial-Loaded Bank Controller

This block is one bank-switching personality of a cartridge mapper. It holds four 5-bit control registers that the CPU cannot write in parallel: each register is loaded one bit per write through a one-bit serial port. A CPU write into the upper half of the address space either shifts data bit 0 into a five-bit shifter or, when data bit 7 is set, restarts the shifter. The fifth shifted bit completes a value, which goes into the register that address bits 14:13 select.

The registers are decoded at once into bank numbers that the surrounding memory logic consumes. These are two 16 KB program slot banks (at 0x8000 and at 0xC000), two 4 KB pattern slot banks, and a two-bit mirroring select. A separate clear pulse, issued when a neighbouring mode register is written, restores the control register, clears the program bank register and empties the shifter. The memory arrays themselves sit outside this block.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset, register 0 holds 0x0C and registers 1 to 3 hold 0. The outputs are then mirror=0, prg_is_32k=0, prg_bank_8000=0, prg_bank_c000=0xF, chr_is_4k=0, chr_bank_0000=0 and chr_bank_1000=1.
- R2: A write is accepted when wr_en=1, active=1 and cpu_addr bit 15=1. With data bit 7 clear, an accepted write shifts data bit 0 in, least significant bit first. On the fifth such write the assembled 5-bit value goes into register cpu_addr[14:13], and the new outputs are visible after that clock edge. Data bits 6:1 and address bits 12:0 are ignored.
- R3: An accepted write with data bit 7 set ORs 0x0C into register 0 and discards any bits collected so far. The next five serial writes then form a complete new value.
- R4: Writes with wr_en=0, with active=0 or with cpu_addr bit 15=0 change no register and do not advance the shifter.
- R5: mirror equals register 0 bits 1:0: 0 is single-screen low, 1 is single-screen high, 2 is vertical and 3 is horizontal.
- R6: When register 0 bit 3 is 1, program banking works in 16 KB units (prg_is_32k=0). If register 0 bit 2 is 1, prg_bank_8000 is register 3 bits 3:0 and prg_bank_c000 is 0xF. If bit 2 is 0, prg_bank_8000 is 0 and prg_bank_c000 is register 3 bits 3:0.
- R7: When register 0 bit 3 is 0, prg_is_32k=1, and the 32 KB bank B is register 3 bits 3:1. The outputs are then prg_bank_8000=2B and prg_bank_c000=2B+1. Register 3 bit 4 never affects program banks.
- R8: When register 0 bit 4 is 1, chr_is_4k=1, chr_bank_0000 is register 1 and chr_bank_1000 is register 2. When it is 0, the 8 KB bank C is register 1 bits 4:1, chr_bank_0000=2C and chr_bank_1000=2C+1.
- R9: A cycle with ext_clear=1 sets register 0 to 0x0C, sets register 3 to 0 and empties the shifter. It keeps registers 1 and 2 and ignores any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active | input | 1 | This personality is selected |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_clear | input | 1 | Clear pulse from the mode register write |
| mirror | output | 2 | Mirroring select |
| prg_is_32k | output | 1 | Program banking in 32 KB units |
| prg_bank_8000 | output | 4 | 16 KB bank mapped at 0x8000 |
| prg_bank_c000 | output | 4 | 16 KB bank mapped at 0xC000 |
| chr_is_4k | output | 1 | Pattern banking in 4 KB units |
| chr_bank_0000 | output | 5 | 4 KB pattern bank at 0x0000 |
| chr_bank_1000 | output | 5 | 4 KB pattern bank at 0x1000 |

## Verification
A wrong bit count or a leftover bit in the shifter shows up as a missing or misplaced register value. The error is visible in the bank outputs one cycle after what should have been the fifth write, so every vector also proves that the shifter was empty before it started. A register committed to the wrong index shows up at once as a bank output change in a field that should not have moved. Stale control bits after a restart write or a clear pulse show up in the next cycle as a wrong mirroring or slot-fixing pattern.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
   localparam int unsigned SB_REG_W    = 5;
   localparam int unsigned SB_NUM_REGS = 4;
   localparam logic [SB_REG_W-1:0] SB_CTRL_INIT = 5'h0C;
   localparam logic [SB_REG_W-1:0] SB_CTRL_FORCE = 5'h0C;

   typedef enum logic [1:0] {
      MIR_ONE_LO = 2'd0,
      MIR_ONE_HI = 2'd1,
      MIR_VERT   = 2'd2,
      MIR_HORZ   = 2'd3
   } mirror_e;
endpackage

// File: rtl/sbc_shifter.sv
module sbc_shifter #(
   parameter int unsigned REG_W = 5,
   localparam int unsigned CNT_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             stb,
   input  logic             restart,
   input  logic             bit_in,
   output logic             soft_rst,
   output logic             commit,
   output logic [REG_W-1:0] commit_val,
   output logic [CNT_W-1:0] bit_cnt
);
   logic [REG_W-1:0] sh_buf;
   logic [REG_W-1:0] next_buf;
   logic             shift;

   assign soft_rst   = stb & restart;
   assign shift      = stb & ~restart;
   assign next_buf   = sh_buf | (REG_W'(bit_in) << bit_cnt);
   assign commit     = shift && (bit_cnt == CNT_W'(REG_W - 1));
   assign commit_val = next_buf;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || soft_rst || commit) begin
         sh_buf  <= '0;
         bit_cnt <= '0;
      end else if (shift) begin
         sh_buf  <= next_buf;
         bit_cnt <= bit_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sbc_regs.sv
module sbc_regs
   import serial_bank_pkg::*;
#(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned NUM_REGS = 4,
   localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             soft_rst,
   input  logic                             commit,
   input  logic [SEL_W-1:0]                 commit_sel,
   input  logic [REG_W-1:0]                 commit_val,
   output logic [NUM_REGS-1:0][REG_W-1:0]   regs
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [REG_W-1:0] INIT = (i == 0) ? REG_W'(SB_CTRL_INIT) : '0;
      logic hit;
      assign hit = commit && (commit_sel == SEL_W'(i));

      if (i == 0) begin : g_ctrl
         always_ff @(posedge clk) begin
            if (!rst_n || clr)  regs[i] <= INIT;
            else if (soft_rst)  regs[i] <= regs[i] | REG_W'(SB_CTRL_FORCE);
            else if (hit)       regs[i] <= commit_val;
         end
      end else if (i == NUM_REGS - 1) begin : g_prg
         always_ff @(posedge clk) begin
            if (!rst_n || clr)  regs[i] <= INIT;
            else if (hit)       regs[i] <= commit_val;
         end
      end else begin : g_chr
         always_ff @(posedge clk) begin
            if (!rst_n)         regs[i] <= INIT;
            else if (hit)       regs[i] <= commit_val;
         end
      end
   end
endmodule

// File: rtl/sbc_decode.sv
module sbc_decode #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned PRG_W    = 4,
   parameter logic [PRG_W-1:0] FIXED_BANK = 4'hF
) (
   input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
   output logic [1:0]                     mirror,
   output logic                           prg_is_32k,
   output logic [PRG_W-1:0]               prg_bank_8000,
   output logic [PRG_W-1:0]               prg_bank_c000,
   output logic                           chr_is_4k,
   output logic [REG_W-1:0]               chr_bank_0000,
   output logic [REG_W-1:0]               chr_bank_1000
);
   localparam int unsigned PRG_REG = NUM_REGS - 1;

   logic [REG_W-1:0] ctrl;
   logic [PRG_W-1:0] prg_sel;
   logic [REG_W-1:0] chr_lo;
   logic             unused_prg_hi;

   assign ctrl          = regs[0];
   assign prg_sel       = regs[PRG_REG][PRG_W-1:0];
   assign chr_lo        = regs[1];
   assign unused_prg_hi = &{1'b0, regs[PRG_REG][REG_W-1:PRG_W]};

   assign mirror     = ctrl[1:0];
   assign prg_is_32k = ~ctrl[3];
   assign chr_is_4k  = ctrl[4];

   always_comb begin
      if (ctrl[3]) begin
         if (ctrl[2]) begin
            prg_bank_8000 = prg_sel;
            prg_bank_c000 = FIXED_BANK;
         end else begin
            prg_bank_8000 = '0;
            prg_bank_c000 = prg_sel;
         end
      end else begin
         prg_bank_8000 = {prg_sel[PRG_W-1:1], 1'b0};
         prg_bank_c000 = {prg_sel[PRG_W-1:1], 1'b1};
      end
   end

   always_comb begin
      if (ctrl[4]) begin
         chr_bank_0000 = chr_lo;
         chr_bank_1000 = regs[2];
      end else begin
         chr_bank_0000 = {chr_lo[REG_W-1:1], 1'b0};
         chr_bank_1000 = {chr_lo[REG_W-1:1], 1'b1};
      end
   end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl #(
   parameter int unsigned REG_W      = 5,
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned PRG_W      = 4,
   parameter int unsigned ADDR_W     = 16,
   parameter logic [PRG_W-1:0] FIXED_BANK = 4'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        wr_data,
   input  logic              ext_clear,
   output logic [1:0]        mirror,
   output logic              prg_is_32k,
   output logic [PRG_W-1:0]  prg_bank_8000,
   output logic [PRG_W-1:0]  prg_bank_c000,
   output logic              chr_is_4k,
   output logic [REG_W-1:0]  chr_bank_0000,
   output logic [REG_W-1:0]  chr_bank_1000
);
   localparam int unsigned SEL_W = $clog2(NUM_REGS);
   localparam int unsigned SEL_LSB = ADDR_W - 1 - SEL_W;
   localparam int unsigned CNT_W = (REG_W > 1) ? $clog2(REG_W) : 1;

   if (REG_W != serial_bank_pkg::SB_REG_W) begin : g_bad_reg_w
      $error("serial_bank_ctrl: REG_W must be 5");
   end
   if (NUM_REGS != serial_bank_pkg::SB_NUM_REGS) begin : g_bad_regs
      $error("serial_bank_ctrl: NUM_REGS must be 4");
   end
   if (PRG_W >= REG_W || PRG_W < 2) begin : g_bad_prg_w
      $error("serial_bank_ctrl: PRG_W must lie in 2..REG_W-1");
   end
   if (ADDR_W < SEL_W + 2) begin : g_bad_addr_w
      $error("serial_bank_ctrl: ADDR_W too small");
   end

   logic                           accept;
   logic                           soft_rst;
   logic                           commit;
   logic [REG_W-1:0]               commit_val;
   logic [CNT_W-1:0]               bit_cnt;
   logic [NUM_REGS-1:0][REG_W-1:0] regs;
   logic                           unused_inputs;

   assign accept = wr_en && active && cpu_addr[ADDR_W-1] && !ext_clear;
   assign unused_inputs = &{1'b0, wr_data[6:1], cpu_addr[SEL_LSB-1:0], bit_cnt};

   sbc_shifter #(.REG_W(REG_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ext_clear),
      .stb        (accept),
      .restart    (wr_data[7]),
      .bit_in     (wr_data[0]),
      .soft_rst   (soft_rst),
      .commit     (commit),
      .commit_val (commit_val),
      .bit_cnt    (bit_cnt)
   );

   sbc_regs #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ext_clear),
      .soft_rst   (soft_rst),
      .commit     (commit),
      .commit_sel (cpu_addr[ADDR_W-2 -: SEL_W]),
      .commit_val (commit_val),
      .regs       (regs)
   );

   sbc_decode #(
      .REG_W(REG_W), .NUM_REGS(NUM_REGS), .PRG_W(PRG_W), .FIXED_BANK(FIXED_BANK)
   ) u_dec (
      .regs          (regs),
      .mirror        (mirror),
      .prg_is_32k    (prg_is_32k),
      .prg_bank_8000 (prg_bank_8000),
      .prg_bank_c000 (prg_bank_c000),
      .chr_is_4k     (chr_is_4k),
      .chr_bank_0000 (chr_bank_0000),
      .chr_bank_1000 (chr_bank_1000)
   );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int unsigned REG_W  = 5,
   parameter int unsigned PRG_W  = 4,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 3,
   parameter logic [PRG_W-1:0] FIXED_BANK = 4'hF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic              wr_en,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [7:0]        wr_data,
   input logic              ext_clear,
   input logic [1:0]        mirror,
   input logic              prg_is_32k,
   input logic [PRG_W-1:0]  prg_bank_8000,
   input logic [PRG_W-1:0]  prg_bank_c000,
   input logic              chr_is_4k,
   input logic [REG_W-1:0]  chr_bank_0000,
   input logic [REG_W-1:0]  chr_bank_1000,
   input logic [CNT_W-1:0]  bit_cnt
);
   logic taken;
   assign taken = wr_en && active && cpu_addr[ADDR_W-1];

   // R2: the shifter never holds five or more pending bits
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < CNT_W'(REG_W));

   // R3: a restart write forces 16 KB mode with the 0xC000 slot fixed
   a_r3_restart_forces_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && wr_data[7] && !ext_clear) |=> (!prg_is_32k && prg_bank_c000 == FIXED_BANK));

   // R4: without an accepted write or clear, no output moves
   a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && !ext_clear) |=> ($stable(mirror) && $stable(prg_is_32k) &&
         $stable(prg_bank_8000) && $stable(prg_bank_c000) && $stable(chr_is_4k) &&
         $stable(chr_bank_0000) && $stable(chr_bank_1000)));

   // R9: a clear pulse restores the control register and empties bank 3
   a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clear |=> (mirror == 2'd0 && !prg_is_32k && !chr_is_4k &&
         prg_bank_8000 == '0 && prg_bank_c000 == FIXED_BANK && bit_cnt == '0));

   // R6: in 16 KB mode one of the two slots is always pinned
   a_r6_one_slot_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      !prg_is_32k |-> (prg_bank_8000 == '0 || prg_bank_c000 == FIXED_BANK));
endmodule

bind serial_bank_ctrl sbc_checker #(
   .REG_W(REG_W), .PRG_W(PRG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIXED_BANK(FIXED_BANK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .active        (active),
   .wr_en         (wr_en),
   .cpu_addr      (cpu_addr),
   .wr_data       (wr_data),
   .ext_clear     (ext_clear),
   .mirror        (mirror),
   .prg_is_32k    (prg_is_32k),
   .prg_bank_8000 (prg_bank_8000),
   .prg_bank_c000 (prg_bank_c000),
   .chr_is_4k     (chr_is_4k),
   .chr_bank_0000 (chr_bank_0000),
   .chr_bank_1000 (chr_bank_1000),
   .bit_cnt       (bit_cnt)
);

// File: tb/serial_bank_ctrl_test.sv
`timescale 1ns/1ps
module serial_bank_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        active = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        ext_clear = 1'b0;
   logic [1:0]  mirror;
   logic        prg_is_32k;
   logic [3:0]  prg_bank_8000;
   logic [3:0]  prg_bank_c000;
   logic        chr_is_4k;
   logic [4:0]  chr_bank_0000;
   logic [4:0]  chr_bank_1000;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   serial_bank_ctrl uut (
      .clk(clk), .rst_n(rst_n), .active(active), .wr_en(wr_en),
      .cpu_addr(cpu_addr), .wr_data(wr_data), .ext_clear(ext_clear),
      .mirror(mirror), .prg_is_32k(prg_is_32k),
      .prg_bank_8000(prg_bank_8000), .prg_bank_c000(prg_bank_c000),
      .chr_is_4k(chr_is_4k), .chr_bank_0000(chr_bank_0000), .chr_bank_1000(chr_bank_1000)
   );

   // {sel, value, mirror, prg_is_32k, prg_8000, prg_c000, chr_is_4k, chr_0000, chr_1000}
   localparam int NVEC = 10;
   localparam logic [28:0] VECS [NVEC] = '{
      {2'd3, 5'h05, 2'd0, 1'b0, 4'h5, 4'hF, 1'b0, 5'h00, 5'h01},
      {2'd0, 5'h0D, 2'd1, 1'b0, 4'h5, 4'hF, 1'b0, 5'h00, 5'h01},
      {2'd0, 5'h0A, 2'd2, 1'b0, 4'h0, 4'h5, 1'b0, 5'h00, 5'h01},
      {2'd0, 5'h03, 2'd3, 1'b1, 4'h4, 4'h5, 1'b0, 5'h00, 5'h01},
      {2'd3, 5'h1E, 2'd3, 1'b1, 4'hE, 4'hF, 1'b0, 5'h00, 5'h01},
      {2'd1, 5'h13, 2'd3, 1'b1, 4'hE, 4'hF, 1'b0, 5'h12, 5'h13},
      {2'd0, 5'h17, 2'd3, 1'b1, 4'hE, 4'hF, 1'b1, 5'h13, 5'h00},
      {2'd2, 5'h0B, 2'd3, 1'b1, 4'hE, 4'hF, 1'b1, 5'h13, 5'h0B},
      {2'd0, 5'h1C, 2'd0, 1'b0, 4'hE, 4'hF, 1'b1, 5'h13, 5'h0B},
      {2'd3, 5'h03, 2'd0, 1'b0, 4'h3, 4'hF, 1'b1, 5'h13, 5'h0B}
   };

   function automatic logic [21:0] observed();
      return {mirror, prg_is_32k, prg_bank_8000, prg_bank_c000,
              chr_is_4k, chr_bank_0000, chr_bank_1000};
   endfunction

   task automatic check(input string req, input logic [21:0] got, input logic [21:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic one_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; cpu_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; cpu_addr = '0; wr_data = '0;
   endtask

   function automatic logic [15:0] reg_addr(input logic [1:0] sel);
      return 16'h8000 | (16'(sel) << 13) | 16'h0155;
   endfunction

   task automatic serial_load(input logic [1:0] sel, input logic [4:0] val);
      for (int b = 0; b < 5; b++)
         one_write(reg_addr(sel), {1'b0, 6'b101010, val[b]});
   endtask

   function automatic logic [21:0] pack(input logic [1:0] m, input logic p32,
      input logic [3:0] p8, input logic [3:0] pc, input logic c4,
      input logic [4:0] c0, input logic [4:0] c1);
      return {m, p32, p8, pc, c4, c0, c1};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset", observed(), pack(2'd0, 1'b0, 4'h0, 4'hF, 1'b0, 5'h00, 5'h01));

      // R2 R5 R6 R7 R8: vector walk
      for (int i = 0; i < NVEC; i++) begin
         serial_load(VECS[i][28:27], VECS[i][26:22]);
         check($sformatf("R2/R5/R6/R7/R8 vector %0d", i), observed(), VECS[i][21:0]);
      end

      // R3: restart write ORs 0x0C into register 0
      serial_load(2'd0, 5'h01);
      check("R7 32k with reg3=3", observed(), pack(2'd1, 1'b1, 4'h2, 4'h3, 1'b0, 5'h12, 5'h13));
      one_write(reg_addr(2'd0), 8'h80);
      check("R3 restart forces 0x0C", observed(), pack(2'd1, 1'b0, 4'h3, 4'hF, 1'b0, 5'h12, 5'h13));
      // R3: partial bits are discarded
      one_write(reg_addr(2'd0), 8'h01);
      one_write(reg_addr(2'd0), 8'h01);
      one_write(reg_addr(2'd0), 8'h80);
      serial_load(2'd3, 5'h06);
      check("R3 partial discarded", observed(), pack(2'd1, 1'b0, 4'h6, 4'hF, 1'b0, 5'h12, 5'h13));

      // R4: ignored writes
      for (int b = 0; b < 5; b++) begin
         @(negedge clk);
         wr_en = 1'b0; cpu_addr = reg_addr(2'd3); wr_data = 8'h01;
      end
      active = 1'b0;
      for (int b = 0; b < 5; b++) one_write(reg_addr(2'd3), 8'h01);
      active = 1'b1;
      for (int b = 0; b < 5; b++) one_write(16'h6000 | 16'h0155, 8'h01);
      @(negedge clk);
      check("R4 ignored writes", observed(), pack(2'd1, 1'b0, 4'h6, 4'hF, 1'b0, 5'h12, 5'h13));
      serial_load(2'd3, 5'h09);
      check("R4 shifter not advanced", observed(), pack(2'd1, 1'b0, 4'h9, 4'hF, 1'b0, 5'h12, 5'h13));

      // R9: clear pulse
      serial_load(2'd1, 5'h07);
      serial_load(2'd0, 5'h12);
      check("R8 4k with R7 32k", observed(), pack(2'd2, 1'b1, 4'h8, 4'h9, 1'b1, 5'h07, 5'h0B));
      one_write(reg_addr(2'd3), 8'h01);
      one_write(reg_addr(2'd3), 8'h01);
      one_write(reg_addr(2'd3), 8'h01);
      @(negedge clk);
      ext_clear = 1'b1; wr_en = 1'b1; cpu_addr = reg_addr(2'd3); wr_data = 8'h01;
      @(negedge clk);
      ext_clear = 1'b0; wr_en = 1'b0; cpu_addr = '0; wr_data = '0;
      check("R9 clear pulse", observed(), pack(2'd0, 1'b0, 4'h0, 4'hF, 1'b0, 5'h06, 5'h07));
      serial_load(2'd3, 5'h04);
      check("R9 shifter emptied", observed(), pack(2'd0, 1'b0, 4'h4, 4'hF, 1'b0, 5'h06, 5'h07));

      // R1: reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset mid-run", observed(), pack(2'd0, 1'b0, 4'h0, 4'hF, 1'b0, 5'h00, 5'h01));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule